// File: doc/BRIEF.md
# Low-Power Mode and Clock-Gating Controller

This block sets the operating mode of a small microcontroller and drives three clock-gating enables from it: one for the CPU clock, one for the on-chip peripheral clocks and one for the real-time-clock domain. Software leaves the run mode by pulsing one of three entry strobes. The strobes select idle, sleep or power-down. In idle only the CPU clock stops. In sleep and power-down the CPU and peripheral clocks both stop. A configuration bit, sampled when a deep mode is entered, decides whether the real-time-clock domain keeps running.

Each mode has its own exit rule. Idle ends on any enabled interrupt request, external or from a peripheral. Sleep ends only on an enabled external interrupt. Power-down ends only on a reset. A hardware reset, a software reset or a watchdog reset always returns the block to run with every clock enabled. The interrupt sources reach the block as raw request lines with a per-line enable. Arbitration among them happens elsewhere.

Top module: `pwr_mode_ctrl`

## Requirements
- R1: Reset returns the block to run mode with all three clock enables at 1.
  - The hardware reset `rst_n` is asynchronous and active low.
  - `sw_rst` and `wdt_rst` are synchronous and take effect at the next rising edge, whatever the mode and whatever other inputs are active.
- R2: `mode` reports the state as run=0, idle=1, power-down=2, sleep=3. A mode change requested by an entry strobe is visible at the first rising edge that samples the strobe.
- R3: If several entry strobes are high in the same run cycle, power-down wins over sleep, and sleep wins over idle.
- R4: In idle, `cpu_clk_en`=0, `per_clk_en`=1 and `rtc_clk_en`=1.
- R5: Idle returns to run at the edge after any line with both its request bit and its enable bit high, external or peripheral. Requests whose enable bit is low, and entry strobes, leave idle unchanged.
- R6: In sleep and power-down, `cpu_clk_en`=0 and `per_clk_en`=0. `rtc_clk_en` equals `rtc_keep` as sampled at the entry edge. Later changes of `rtc_keep` have no effect until the next entry.
- R7: Sleep returns to run only at the edge after an enabled external interrupt. Peripheral requests and masked external requests leave sleep unchanged.
- R8: Power-down is left only through reset. Every interrupt line and every entry strobe is ignored there.
- R9: An enabled interrupt request in the same cycle as an entry strobe in run cancels the entry, and the block stays in run.
- R10: The clock enables are register outputs. They change only at the edge where the mode changes and hold steady in every other cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Always-running controller clock |
| rst_n | input | 1 | Asynchronous hardware reset, active low |
| sw_rst | input | 1 | Synchronous software reset |
| wdt_rst | input | 1 | Synchronous watchdog reset |
| enter_idle | input | 1 | Strobe requesting idle |
| enter_pdown | input | 1 | Strobe requesting power-down |
| enter_sleep | input | 1 | Strobe requesting sleep |
| rtc_keep | input | 1 | Keep the real-time-clock domain clocked in deep modes |
| ext_irq | input | N_EXT | External interrupt request lines |
| ext_irq_en | input | N_EXT | Per-line enables for external requests |
| per_irq | input | N_PER | Peripheral interrupt request lines |
| per_irq_en | input | N_PER | Per-line enables for peripheral requests |
| cpu_clk_en | output | 1 | Gate enable for the CPU clock |
| per_clk_en | output | 1 | Gate enable for the peripheral clocks |
| rtc_clk_en | output | 1 | Gate enable for the real-time-clock domain |
| mode | output | 2 | Current mode code |

## Verification
The assertions assume that `sw_rst`, `wdt_rst`, the strobes and the interrupt lines are synchronous to `clk` and are stable around each rising edge. They also assume that `rst_n` is low from time zero until the first edges have passed. The bench drives every input on the falling edge and holds it for a full cycle. It releases `rst_n` only after several edges of reset. It samples the outputs one falling edge later, after exactly one rising edge, so every check lands on the register update that the strobe or request caused.

// File: rtl/pwr_mode_pkg.sv
package pwr_mode_pkg;

    typedef enum logic [1:0] {
        PM_RUN   = 2'd0,
        PM_IDLE  = 2'd1,
        PM_PDOWN = 2'd2,
        PM_SLEEP = 2'd3
    } pm_state_e;

    typedef struct packed {
        pm_state_e st;
    } fsm_reg_t;

    typedef struct packed {
        logic cpu;
        logic per;
        logic rtc;
    } clk_en_t;

    function automatic logic pm_is_deep(input pm_state_e s);
        return (s == PM_PDOWN) || (s == PM_SLEEP);
    endfunction

endpackage

// File: rtl/pwr_wake_qual.sv
module pwr_wake_qual #(
    parameter int N_EXT = 4,
    parameter int N_PER = 8
) (
    input  logic [N_EXT-1:0] ext_irq,
    input  logic [N_EXT-1:0] ext_irq_en,
    input  logic [N_PER-1:0] per_irq,
    input  logic [N_PER-1:0] per_irq_en,
    output logic             wake_ext,
    output logic             wake_any
);
    logic [N_EXT-1:0] ext_live;
    logic [N_PER-1:0] per_live;

    for (genvar g = 0; g < N_EXT; g++) begin : g_ext
        assign ext_live[g] = ext_irq[g] & ext_irq_en[g];
    end

    for (genvar g = 0; g < N_PER; g++) begin : g_per
        assign per_live[g] = per_irq[g] & per_irq_en[g];
    end

    assign wake_ext = |ext_live;
    assign wake_any = wake_ext | (|per_live);

endmodule

// File: rtl/pwr_mode_fsm.sv
module pwr_mode_fsm
    import pwr_mode_pkg::*;
(
    input  logic      clk,
    input  logic      rst_n,
    input  logic      sync_rst,
    input  logic      ent_idle,
    input  logic      ent_pdown,
    input  logic      ent_sleep,
    input  logic      wake_ext,
    input  logic      wake_any,
    output pm_state_e state_q,
    output pm_state_e state_d
);
    fsm_reg_t r_d, r_q;

    always_comb begin
        r_d = r_q;
        if (sync_rst) begin
            r_d.st = PM_RUN;
        end else begin
            unique case (r_q.st)
                PM_RUN: begin
                    if (wake_any)       r_d.st = PM_RUN;
                    else if (ent_pdown) r_d.st = PM_PDOWN;
                    else if (ent_sleep) r_d.st = PM_SLEEP;
                    else if (ent_idle)  r_d.st = PM_IDLE;
                end
                PM_IDLE:  if (wake_any) r_d.st = PM_RUN;
                PM_SLEEP: if (wake_ext) r_d.st = PM_RUN;
                PM_PDOWN: r_d.st = PM_PDOWN;
                default:  r_d.st = PM_RUN;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) r_q <= '{st: PM_RUN};
        else        r_q <= r_d;
    end

    assign state_q = r_q.st;
    assign state_d = r_d.st;

    // R1
    sync_reset_to_run_chk: assert property (@(posedge clk) disable iff (!rst_n)
        sync_rst |=> state_q == PM_RUN);

    // R8
    pdown_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == PM_PDOWN && !sync_rst) |=> state_q == PM_PDOWN);

    // R5
    idle_exit_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == PM_IDLE && wake_any && !sync_rst) |=> state_q == PM_RUN);

    // R7
    sleep_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == PM_SLEEP && !wake_ext && !sync_rst) |=> state_q == PM_SLEEP);

    // R9
    entry_cancel_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == PM_RUN && wake_any) |=> state_q == PM_RUN);

endmodule

// File: rtl/pwr_clk_en.sv
module pwr_clk_en
    import pwr_mode_pkg::*;
(
    input  logic      clk,
    input  logic      rst_n,
    input  logic      sync_rst,
    input  logic      rtc_keep,
    input  pm_state_e state_q,
    input  pm_state_e state_d,
    output logic      cpu_en,
    output logic      per_en,
    output logic      rtc_en
);
    clk_en_t en_d, en_q;

    always_comb begin
        en_d = en_q;
        if (sync_rst) begin
            en_d = '{cpu: 1'b1, per: 1'b1, rtc: 1'b1};
        end else if (state_d != state_q) begin
            unique case (state_d)
                PM_RUN:   en_d = '{cpu: 1'b1, per: 1'b1, rtc: 1'b1};
                PM_IDLE:  en_d = '{cpu: 1'b0, per: 1'b1, rtc: 1'b1};
                default:  en_d = '{cpu: 1'b0, per: 1'b0, rtc: rtc_keep};
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) en_q <= '{cpu: 1'b1, per: 1'b1, rtc: 1'b1};
        else        en_q <= en_d;
    end

    assign cpu_en = en_q.cpu;
    assign per_en = en_q.per;
    assign rtc_en = en_q.rtc;

    // R4
    cpu_only_in_run_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cpu_en == (state_q == PM_RUN));

    // R6
    per_off_when_deep_chk: assert property (@(posedge clk) disable iff (!rst_n)
        per_en == !pm_is_deep(state_q));

    // R10
    en_steady_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!sync_rst && state_d == state_q) |=> $stable(en_q));

endmodule

// File: rtl/pwr_mode_ctrl.sv
module pwr_mode_ctrl
    import pwr_mode_pkg::*;
#(
    parameter int N_EXT = 4,
    parameter int N_PER = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             sw_rst,
    input  logic             wdt_rst,
    input  logic             enter_idle,
    input  logic             enter_pdown,
    input  logic             enter_sleep,
    input  logic             rtc_keep,
    input  logic [N_EXT-1:0] ext_irq,
    input  logic [N_EXT-1:0] ext_irq_en,
    input  logic [N_PER-1:0] per_irq,
    input  logic [N_PER-1:0] per_irq_en,
    output logic             cpu_clk_en,
    output logic             per_clk_en,
    output logic             rtc_clk_en,
    output logic [1:0]       mode
);
    logic      sync_rst;
    logic      wake_ext, wake_any;
    pm_state_e st_q, st_d;

    assign sync_rst = sw_rst | wdt_rst;

    pwr_wake_qual #(.N_EXT(N_EXT), .N_PER(N_PER)) u_wake (
        .ext_irq   (ext_irq),
        .ext_irq_en(ext_irq_en),
        .per_irq   (per_irq),
        .per_irq_en(per_irq_en),
        .wake_ext  (wake_ext),
        .wake_any  (wake_any)
    );

    pwr_mode_fsm u_fsm (
        .clk      (clk),
        .rst_n    (rst_n),
        .sync_rst (sync_rst),
        .ent_idle (enter_idle),
        .ent_pdown(enter_pdown),
        .ent_sleep(enter_sleep),
        .wake_ext (wake_ext),
        .wake_any (wake_any),
        .state_q  (st_q),
        .state_d  (st_d)
    );

    pwr_clk_en u_en (
        .clk     (clk),
        .rst_n   (rst_n),
        .sync_rst(sync_rst),
        .rtc_keep(rtc_keep),
        .state_q (st_q),
        .state_d (st_d),
        .cpu_en  (cpu_clk_en),
        .per_en  (per_clk_en),
        .rtc_en  (rtc_clk_en)
    );

    assign mode = st_q;

    // R2
    strobe_to_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (mode == 2'd0 && enter_idle && !enter_pdown && !enter_sleep && !wake_any && !sync_rst)
        |=> mode == 2'd1);

endmodule

// File: tb/pwr_mode_ctrl_tb.sv
module pwr_mode_ctrl_tb_top;

    localparam int NE = 2;
    localparam int NP = 4;

    typedef struct packed {
        logic [3:0]    req;
        logic [2:0]    ent;   // {idle, pdown, sleep}
        logic [NE-1:0] ext;
        logic [NE-1:0] ext_en;
        logic [NP-1:0] per;
        logic [NP-1:0] per_en;
        logic          keep;
        logic          srst;
        logic [1:0]    mode;
        logic          cpu;
        logic          pclk;
        logic          rtc;
    } row_t;

    localparam int NR = 24;
    localparam row_t TBL [0:NR-1] = '{
        '{4'd1,  3'b000, 2'b00, 2'b00, 4'h0, 4'h0, 1'b1, 1'b0, 2'd0, 1'b1, 1'b1, 1'b1}, // R1 idle run
        '{4'd2,  3'b100, 2'b00, 2'b00, 4'h0, 4'h0, 1'b1, 1'b0, 2'd1, 1'b0, 1'b1, 1'b1}, // R2 R4 to idle
        '{4'd5,  3'b000, 2'b00, 2'b00, 4'h1, 4'h0, 1'b1, 1'b0, 2'd1, 1'b0, 1'b1, 1'b1}, // R5 masked
        '{4'd5,  3'b010, 2'b00, 2'b00, 4'h0, 4'h0, 1'b1, 1'b0, 2'd1, 1'b0, 1'b1, 1'b1}, // R5 strobe ignored
        '{4'd5,  3'b000, 2'b00, 2'b00, 4'h1, 4'h1, 1'b1, 1'b0, 2'd0, 1'b1, 1'b1, 1'b1}, // R5 periph wake
        '{4'd6,  3'b001, 2'b00, 2'b00, 4'h0, 4'h0, 1'b1, 1'b0, 2'd3, 1'b0, 1'b0, 1'b1}, // R6 sleep rtc on
        '{4'd6,  3'b000, 2'b00, 2'b00, 4'h0, 4'h0, 1'b0, 1'b0, 2'd3, 1'b0, 1'b0, 1'b1}, // R6 keep change ignored
        '{4'd7,  3'b000, 2'b00, 2'b00, 4'hF, 4'hF, 1'b0, 1'b0, 2'd3, 1'b0, 1'b0, 1'b1}, // R7 periph ignored
        '{4'd7,  3'b000, 2'b01, 2'b00, 4'h0, 4'h0, 1'b0, 1'b0, 2'd3, 1'b0, 1'b0, 1'b1}, // R7 masked ext
        '{4'd7,  3'b000, 2'b01, 2'b01, 4'h0, 4'h0, 1'b0, 1'b0, 2'd0, 1'b1, 1'b1, 1'b1}, // R7 ext wake
        '{4'd6,  3'b001, 2'b00, 2'b00, 4'h0, 4'h0, 1'b0, 1'b0, 2'd3, 1'b0, 1'b0, 1'b0}, // R6 sleep rtc off
        '{4'd7,  3'b000, 2'b10, 2'b10, 4'h0, 4'h0, 1'b1, 1'b0, 2'd0, 1'b1, 1'b1, 1'b1}, // R7 ext line 1
        '{4'd8,  3'b010, 2'b00, 2'b00, 4'h0, 4'h0, 1'b1, 1'b0, 2'd2, 1'b0, 1'b0, 1'b1}, // R8 pdown
        '{4'd8,  3'b101, 2'b11, 2'b11, 4'hF, 4'hF, 1'b0, 1'b0, 2'd2, 1'b0, 1'b0, 1'b1}, // R8 all ignored
        '{4'd1,  3'b000, 2'b00, 2'b00, 4'h0, 4'h0, 1'b1, 1'b1, 2'd0, 1'b1, 1'b1, 1'b1}, // R1 sw reset
        '{4'd9,  3'b100, 2'b00, 2'b00, 4'h2, 4'h2, 1'b1, 1'b0, 2'd0, 1'b1, 1'b1, 1'b1}, // R9 cancel idle
        '{4'd9,  3'b001, 2'b01, 2'b01, 4'h0, 4'h0, 1'b1, 1'b0, 2'd0, 1'b1, 1'b1, 1'b1}, // R9 cancel sleep
        '{4'd3,  3'b111, 2'b00, 2'b00, 4'h0, 4'h0, 1'b0, 1'b0, 2'd2, 1'b0, 1'b0, 1'b0}, // R3 pdown wins
        '{4'd1,  3'b000, 2'b00, 2'b00, 4'h0, 4'h0, 1'b1, 1'b1, 2'd0, 1'b1, 1'b1, 1'b1}, // R1
        '{4'd3,  3'b101, 2'b00, 2'b00, 4'h0, 4'h0, 1'b1, 1'b0, 2'd3, 1'b0, 1'b0, 1'b1}, // R3 sleep over idle
        '{4'd10, 3'b000, 2'b00, 2'b00, 4'h1, 4'h0, 1'b0, 1'b0, 2'd3, 1'b0, 1'b0, 1'b1}, // R10 steady
        '{4'd1,  3'b000, 2'b00, 2'b00, 4'h0, 4'h0, 1'b1, 1'b1, 2'd0, 1'b1, 1'b1, 1'b1}, // R1
        '{4'd3,  3'b110, 2'b00, 2'b00, 4'h0, 4'h0, 1'b1, 1'b0, 2'd2, 1'b0, 1'b0, 1'b1}, // R3 pdown over idle
        '{4'd1,  3'b000, 2'b00, 2'b00, 4'h0, 4'h0, 1'b1, 1'b1, 2'd0, 1'b1, 1'b1, 1'b1}  // R1
    };

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          sw_rst = 1'b0, wdt_rst = 1'b0;
    logic          enter_idle = 1'b0, enter_pdown = 1'b0, enter_sleep = 1'b0;
    logic          rtc_keep = 1'b1;
    logic [NE-1:0] ext_irq = '0, ext_irq_en = '0;
    logic [NP-1:0] per_irq = '0, per_irq_en = '0;
    logic          cpu_clk_en, per_clk_en, rtc_clk_en;
    logic [1:0]    mode;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #2 clk = ~clk;

    pwr_mode_ctrl #(.N_EXT(NE), .N_PER(NP)) dut_i (
        .clk(clk), .rst_n(rst_n), .sw_rst(sw_rst), .wdt_rst(wdt_rst),
        .enter_idle(enter_idle), .enter_pdown(enter_pdown), .enter_sleep(enter_sleep),
        .rtc_keep(rtc_keep), .ext_irq(ext_irq), .ext_irq_en(ext_irq_en),
        .per_irq(per_irq), .per_irq_en(per_irq_en),
        .cpu_clk_en(cpu_clk_en), .per_clk_en(per_clk_en), .rtc_clk_en(rtc_clk_en),
        .mode(mode)
    );

    task automatic expect_out(input int req, input logic [1:0] m,
                              input logic c, input logic p, input logic r);
        checks++;
        if (mode !== m || cpu_clk_en !== c || per_clk_en !== p || rtc_clk_en !== r) begin
            errors++;
            $display("FAIL R%0d: mode/cpu/per/rtc got %0d/%b/%b/%b expected %0d/%b/%b/%b",
                     req, mode, cpu_clk_en, per_clk_en, rtc_clk_en, m, c, p, r);
        end
    endtask

    task automatic quiet();
        sw_rst = 0; wdt_rst = 0;
        enter_idle = 0; enter_pdown = 0; enter_sleep = 0;
        ext_irq = '0; ext_irq_en = '0; per_irq = '0; per_irq_en = '0;
    endtask

    initial begin
        repeat (50000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog: run did not complete, got hang expected finish");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        expect_out(1, 2'd0, 1'b1, 1'b1, 1'b1); // R1 during hardware reset
        rst_n = 1'b1;
        @(negedge clk);
        expect_out(1, 2'd0, 1'b1, 1'b1, 1'b1); // R1 after release

        for (int i = 0; i < NR; i++) begin
            enter_idle  = TBL[i].ent[2];
            enter_pdown = TBL[i].ent[1];
            enter_sleep = TBL[i].ent[0];
            ext_irq     = TBL[i].ext;
            ext_irq_en  = TBL[i].ext_en;
            per_irq     = TBL[i].per;
            per_irq_en  = TBL[i].per_en;
            rtc_keep    = TBL[i].keep;
            sw_rst      = TBL[i].srst;
            wdt_rst     = 1'b0;
            @(negedge clk);
            expect_out(int'(TBL[i].req), TBL[i].mode, TBL[i].cpu, TBL[i].pclk, TBL[i].rtc);
        end

        // R10: enables steady across several idle cycles
        quiet(); enter_idle = 1;
        @(negedge clk);
        quiet();
        for (int k = 0; k < 4; k++) begin
            @(negedge clk);
            expect_out(10, 2'd1, 1'b0, 1'b1, 1'b1);
        end
        // R5 external wake from idle
        ext_irq = 2'b10; ext_irq_en = 2'b11;
        @(negedge clk);
        expect_out(5, 2'd0, 1'b1, 1'b1, 1'b1);

        // R1 watchdog reset from sleep
        quiet(); rtc_keep = 0; enter_sleep = 1;
        @(negedge clk);
        expect_out(6, 2'd3, 1'b0, 1'b0, 1'b0);
        quiet(); wdt_rst = 1;
        @(negedge clk);
        expect_out(1, 2'd0, 1'b1, 1'b1, 1'b1);

        // R1 software reset beats a simultaneous entry strobe
        quiet(); sw_rst = 1; enter_pdown = 1;
        @(negedge clk);
        expect_out(1, 2'd0, 1'b1, 1'b1, 1'b1);

        // R1 asynchronous hardware reset out of power-down
        quiet(); rtc_keep = 1; enter_pdown = 1;
        @(negedge clk);
        expect_out(8, 2'd2, 1'b0, 1'b0, 1'b1);
        quiet();
        #1 rst_n = 1'b0;
        #0.5;
        expect_out(1, 2'd0, 1'b1, 1'b1, 1'b1);
        @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        expect_out(1, 2'd0, 1'b1, 1'b1, 1'b1);

        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule